// File: doc/BRIEF.md
# Code-Group Serializer with Wrap Path

This block turns 10-bit code groups that are already line-coded into a serial bit stream. The whole block runs on the fast bit clock. A strobe that is high for one cycle in every ten stands in for the edge of the slower code-group clock. On a strobe the block captures the parallel word. It then sends the word out one bit per cycle, starting with bit 0. The block does no encoding of its own, so every bit of the word reaches the stream unchanged.

Two controls decide where the stream goes. With wrap low, the serial line carries the stream and the receive side takes its bit from the line input. With wrap high, the stream goes to the receive side in place of the line input and the line is held at logic 1. An output-enable control sets the line to high impedance when it is low, whatever wrap is doing. The line is reported as a 2-bit state. Bit 1 says whether the line is driven, and bit 0 gives the driven level.

Top module: `cg_serializer`

## Requirements
- R1: When `cg_strobe` is high at a rising clock edge, the word on `cg_word` is captured, and `ser_bit` shows bit 0 of that word for the whole following cycle.
- R2: In the k-th cycle after the capture edge (k from 0 to 9), `ser_bit` equals bit k of the captured word. Bits leave LSB first and without alteration.
- R3: A strobe that arrives exactly ten cycles after the previous one captures the next word, and its bit 0 follows bit 9 of the previous word with no gap cycle.
- R4: While `rst_n` is low at a clock edge, the shift register and the bit counter are cleared. From then until the next capture, `ser_bit` is 0, including when the reset cuts into a word.
- R5: Once all ten bits of a word have been sent and no new strobe has come, `ser_bit` is 0.
- R6: When `line_oe` is low, `line_state` is 2'b00 (high impedance), whatever `wrap_en` and the stream are doing.
- R7: When `line_oe` is high and `wrap_en` is high, `line_state` is 2'b11 (drive 1) while the stream keeps running.
- R8: When `line_oe` is high and `wrap_en` is low, `line_state` is 2'b10 while `ser_bit` is 0 and 2'b11 while `ser_bit` is 1.
- R9: `rx_serial` equals `ser_bit` when `wrap_en` is high and equals `line_rx_in` when `wrap_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cg_strobe | input | 1 | One-cycle capture strobe, one in every CG_W cycles |
| cg_word | input | CG_W (10) | Encoded code group to capture |
| wrap_en | input | 1 | Sends the stream to the receive side and holds the line at 1 |
| line_oe | input | 1 | Line output enable; low gives high impedance |
| line_rx_in | input | 1 | Serial bit arriving from the line |
| ser_bit | output | 1 | Serial transmit stream, LSB first |
| line_state | output | 2 | Line condition: 00 high impedance, 10 drive 0, 11 drive 1 |
| rx_serial | output | 1 | Serial bit handed to the receive side |

## Verification
The checker assumes that `cg_strobe` only rises in two situations. One is the tenth cycle after the previous capture. The other is any cycle once the previous word has been fully sent. A strobe-spacing property flags any other timing. The stimulus sends all 1024 code-group values back to back, with one strobe every ten cycles. It then stops strobing to let the stream drain, and it applies a reset only between strobes. Wrap and enable change only on word boundaries. The line input is toggled every cycle, so that both sources of the receive side can be told apart.

// File: rtl/cg_ser_pkg.sv
// Shared types for the code-group serializer.
// Assumes: the line state is read as {driven, level}.
package cg_ser_pkg;
    typedef enum logic [1:0] {
        LINE_HIZ  = 2'b00,
        LINE_LOW  = 2'b10,
        LINE_HIGH = 2'b11
    } line_state_e;
endpackage

// File: rtl/cg_bit_counter.sv
// Counts the bit slots of the word being sent.
// Assumes: a load restarts the count; CG_W means idle (no word in flight).
module cg_bit_counter #(
    parameter int CG_W = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CNT_W = $clog2(CG_W + 1);
    localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(CG_W);

    logic [CNT_W-1:0] cnt_q;

    // Track the bit slot: restart on load, stop at the idle value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= IDLE_CNT;
        else if (load)
            cnt_q <= '0;
        else if (cnt_q != IDLE_CNT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign busy = (cnt_q != IDLE_CNT);
endmodule

// File: rtl/cg_shift_unit.sv
// Captures a code group and shifts it out LSB first.
// Assumes: load is asserted only when the previous word is done or on its last bit.
module cg_shift_unit #(
    parameter int CG_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [CG_W-1:0] word,
    input  logic            busy,
    output logic            ser_bit
);
    logic [CG_W-1:0] shreg_q;

    // Capture the word on load, otherwise move the next bit into position 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            shreg_q <= '0;
        else if (load)
            shreg_q <= word;
        else
            shreg_q <= {1'b0, shreg_q[CG_W-1:1]};
    end

    // Send the low bit only while a word is in flight.
    assign ser_bit = busy & shreg_q[0];
endmodule

// File: rtl/cg_line_ctrl.sv
// Chooses the line state and the source of the receive-side bit.
// Assumes: enable takes priority over wrap for the line.
module cg_line_ctrl
    import cg_ser_pkg::*;
(
    input  logic        ser_bit,
    input  logic        wrap_en,
    input  logic        line_oe,
    input  logic        line_rx_in,
    output line_state_e line_state,
    output logic        rx_serial
);
    // Line state: float, hold high in wrap, or follow the stream.
    always_comb begin
        if (!line_oe)
            line_state = LINE_HIZ;
        else if (wrap_en)
            line_state = LINE_HIGH;
        else
            line_state = ser_bit ? LINE_HIGH : LINE_LOW;
    end

    // Receive source: stream in wrap, line otherwise.
    always_comb begin
        rx_serial = wrap_en ? ser_bit : line_rx_in;
    end
endmodule

// File: rtl/cg_serializer.sv
// Top of the code-group serializer with wrap path.
// Assumes: one clock domain at bit rate; cg_strobe marks code-group edges.
module cg_serializer
    import cg_ser_pkg::*;
#(
    parameter int CG_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cg_strobe,
    input  logic [CG_W-1:0] cg_word,
    input  logic            wrap_en,
    input  logic            line_oe,
    input  logic            line_rx_in,
    output logic            ser_bit,
    output logic [1:0]      line_state,
    output logic            rx_serial
);
    logic        busy;
    line_state_e state_e;

    cg_bit_counter #(.CG_W(CG_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cg_strobe),
        .busy  (busy)
    );

    cg_shift_unit #(.CG_W(CG_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cg_strobe),
        .word    (cg_word),
        .busy    (busy),
        .ser_bit (ser_bit)
    );

    cg_line_ctrl u_line (
        .ser_bit    (ser_bit),
        .wrap_en    (wrap_en),
        .line_oe    (line_oe),
        .line_rx_in (line_rx_in),
        .line_state (state_e),
        .rx_serial  (rx_serial)
    );

    assign line_state = state_e;
endmodule

// File: rtl/cg_serializer_chk.sv
// Checker for cg_serializer, tied on through bind.
// Assumes: the same clock and synchronous active-low reset as the design.
module cg_serializer_chk #(
    parameter int CG_W = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cg_strobe,
    input logic [CG_W-1:0] cg_word,
    input logic            wrap_en,
    input logic            line_oe,
    input logic            line_rx_in,
    input logic            ser_bit,
    input logic [1:0]      line_state,
    input logic            rx_serial
);
    localparam int SL_W = $clog2(CG_W + 1);
    localparam logic [SL_W-1:0] SL_MAX = SL_W'(CG_W);

    logic [SL_W-1:0] since_load;
    logic [1:0]      since_rst;

    // Count cycles since the last capture, saturating at CG_W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_load <= SL_MAX;
        else if (cg_strobe)
            since_load <= '0;
        else if (since_load != SL_MAX)
            since_load <= since_load + 1'b1;
    end

    // Count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 1'b1;
    end

    // Input assumption: strobe spacing
    strobe_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cg_strobe |-> (since_load == SL_MAX || since_load == SL_MAX - 1'b1));

    // R1
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(cg_strobe)) |-> ser_bit == $past(cg_word[0]));

    // R2
    second_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(cg_strobe, 2) && !$past(cg_strobe))
        |-> ser_bit == $past(cg_word[1], 2));

    // R4 R5
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_load == SL_MAX) |-> !ser_bit);

    // R6
    float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_oe |-> line_state == 2'b00);

    // R7
    wrap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && wrap_en) |-> line_state == 2'b11);

    // R8
    line_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !wrap_en) |-> line_state == {1'b1, ser_bit});

    // R9
    rx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_serial == (wrap_en ? ser_bit : line_rx_in));
endmodule

bind cg_serializer cg_serializer_chk #(.CG_W(CG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cg_strobe  (cg_strobe),
    .cg_word    (cg_word),
    .wrap_en    (wrap_en),
    .line_oe    (line_oe),
    .line_rx_in (line_rx_in),
    .ser_bit    (ser_bit),
    .line_state (line_state),
    .rx_serial  (rx_serial)
);

// File: tb/cg_serializer_tb.sv
// Bench for cg_serializer: sends every 10-bit word back to back and checks each bit slot.
module cg_serializer_tb;
    localparam int CG_W = 10;
    localparam int NWORDS = 1 << CG_W;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cg_strobe;
    logic [CG_W-1:0] cg_word;
    logic            wrap_en;
    logic            line_oe;
    logic            line_rx_in;
    logic            ser_bit;
    logic [1:0]      line_state;
    logic            rx_serial;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    cg_serializer #(.CG_W(CG_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cg_strobe  (cg_strobe),
        .cg_word    (cg_word),
        .wrap_en    (wrap_en),
        .line_oe    (line_oe),
        .line_rx_in (line_rx_in),
        .ser_bit    (ser_bit),
        .line_state (line_state),
        .rx_serial  (rx_serial)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    function automatic int exp_line(input bit oe, input bit wrap, input bit b);
        if (!oe) return 0;
        if (wrap) return 3;
        return b ? 3 : 2;
    endfunction

    initial begin
        logic [CG_W-1:0] cur_word;
        bit cur_wrap, cur_oe;
        rst_n = 1'b0; cg_strobe = 1'b0; cg_word = '0;
        wrap_en = 1'b0; line_oe = 1'b1; line_rx_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state: idle stream, line drives 0, receive follows line (R4 R8 R9)
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check("R4 idle after reset", ser_bit, 0);
            check("R8 idle line", line_state, 2);
            check("R9 rx from line", rx_serial, line_rx_in);
            line_rx_in = c[0];
        end

        // Sweep all words back to back (R1 R2 R3 R6 R7 R8 R9)
        cur_word = '0; cur_wrap = 1'b0; cur_oe = 1'b0;
        cg_strobe = 1'b1; cg_word = cur_word; wrap_en = cur_wrap; line_oe = cur_oe;
        for (int i = 0; i < NWORDS; i++) begin
            for (int k = 0; k < CG_W; k++) begin
                @(negedge clk);
                if (k == 0)
                    check(i == 0 ? "R1 first bit" : "R3 no gap next word",
                          ser_bit, cur_word[k]);
                else
                    check("R2 LSB-first bit", ser_bit, cur_word[k]);
                check(!cur_oe ? "R6 float" : (cur_wrap ? "R7 wrap hold" : "R8 line follow"),
                      line_state, exp_line(cur_oe, cur_wrap, cur_word[k]));
                check("R9 rx source", rx_serial, cur_wrap ? int'(cur_word[k]) : int'(line_rx_in));
                line_rx_in = k[0] ^ i[1];
                if (k == CG_W - 1 && i < NWORDS - 1) begin
                    cur_word = CG_W'(i + 1);
                    cur_wrap = cur_word[0] ^ cur_word[4];
                    cur_oe   = ((i + 1) % 3) != 0;
                    cg_strobe = 1'b1; cg_word = cur_word;
                    wrap_en = cur_wrap; line_oe = cur_oe;
                end else begin
                    cg_strobe = 1'b0;
                end
            end
        end

        // Drain: no strobe, stream returns to 0 (R5)
        wrap_en = 1'b0; line_oe = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R5 drained stream", ser_bit, 0);
            check("R8 drained line", line_state, 2);
        end

        // Reset in the middle of a word (R4)
        cg_strobe = 1'b1; cg_word = '1;
        @(negedge clk);
        cg_strobe = 1'b0;
        check("R1 all-ones first bit", ser_bit, 1);
        @(negedge clk);
        check("R2 all-ones second bit", ser_bit, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R4 cleared mid-word", ser_bit, 0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule